// File: doc/BRIEF.md
# Burst Address Counter

This block produces the address that one port of a synchronous memory presents to its array. On every rising clock edge it either takes an address from outside, steps its stored address up by one, forces the address to zero, or keeps the address it already has. Three active-low controls select the action, and all three are sampled on the clock edge.

The controls resolve in a fixed order. The counter clear wins over everything else. The address strobe comes next, and the count enable acts only when neither of the other two is low. Counting covers the whole address space. After the top address the count returns to zero, so a long burst can run around the array without help from outside. The address width is a parameter. Its default of 15 bits covers 32K words.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_ni` is low, `addr_o` is zero, with or without a clock edge.
- R2: When `cnt_rst_ni` is high and `strobe_ni` is low at a rising edge, `addr_o` after that edge equals the `addr_i` value sampled at the edge.
- R3: When `cnt_rst_ni` and `strobe_ni` are high and `cnt_en_ni` is low at a rising edge, `addr_o` increases by exactly one at that edge.
- R4: When `cnt_rst_ni` is low at a rising edge, `addr_o` becomes zero at that edge, whatever the values of `strobe_ni`, `cnt_en_ni` and `addr_i`.
- R5: When `strobe_ni` and `cnt_en_ni` are both low and `cnt_rst_ni` is high, the count enable is ignored. `addr_o` takes the sampled `addr_i` value and not `addr_i + 1`.
- R6: An increment from the all-ones address (2^ADDR_W − 1) gives zero.
- R7: When `strobe_ni`, `cnt_en_ni` and `cnt_rst_ni` are all high at a rising edge, `addr_o` keeps its value, whatever `addr_i` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all actions take place on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset; clears the address |
| addr_i | input | ADDR_W | Address taken in when the strobe is low |
| strobe_ni | input | 1 | Active-low address strobe (load) |
| cnt_en_ni | input | 1 | Active-low count enable (increment) |
| cnt_rst_ni | input | 1 | Active-low counter clear (to zero) |
| addr_o | output | ADDR_W | Registered address sent to the array |

## Verification
The properties assume that the three controls and `addr_i` are settled and free of X at each rising edge while `rst_ni` is high. They make no assumption about how the controls combine, because every combination has a defined result. The stimulus changes inputs only on the falling edge. It mixes directed sequences (load near the top address and then count across the wrap, conflicts between controls, reset in the middle of a run) with random patterns. The random patterns favour runs of increments and a loaded address close to all ones, so that the wrap happens often.

// File: rtl/burst_ctr_pkg.sv
package burst_ctr_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_INC  = 2'd1,
    OP_LOAD = 2'd2,
    OP_CLR  = 2'd3
  } ctr_op_e;
endpackage

// File: rtl/burst_ctr_decode.sv
module burst_ctr_decode
  import burst_ctr_pkg::*;
(
  input  logic    strobe_ni,
  input  logic    cnt_en_ni,
  input  logic    cnt_rst_ni,
  output ctr_op_e op_o
);
  // fixed priority: clear > load > increment > hold
  always_comb begin
    if (!cnt_rst_ni)     op_o = OP_CLR;
    else if (!strobe_ni) op_o = OP_LOAD;
    else if (!cnt_en_ni) op_o = OP_INC;
    else                 op_o = OP_HOLD;
  end
endmodule

// File: rtl/burst_ctr_next.sv
module burst_ctr_next
  import burst_ctr_pkg::*;
#(
  parameter int unsigned ADDR_W = 15
) (
  input  ctr_op_e           op_i,
  input  logic [ADDR_W-1:0] cur_i,
  input  logic [ADDR_W-1:0] load_i,
  output logic [ADDR_W-1:0] nxt_o
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] inc_val;
  assign inc_val = cur_i + ONE;  // wraps modulo 2^ADDR_W

  always_comb begin
    unique case (op_i)
      OP_CLR:  nxt_o = '0;
      OP_LOAD: nxt_o = load_i;
      OP_INC:  nxt_o = inc_val;
      default: nxt_o = cur_i;
    endcase
  end
endmodule

// File: rtl/burst_ctr_reg.sv
module burst_ctr_reg #(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] d_i,
  output logic [ADDR_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_ctr_pkg::*;
#(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              strobe_ni,
  input  logic              cnt_en_ni,
  input  logic              cnt_rst_ni,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] ADDR_MAX = {ADDR_W{1'b1}};

  ctr_op_e           op;
  logic [ADDR_W-1:0] nxt;

  burst_ctr_decode u_decode (
    .strobe_ni (strobe_ni),
    .cnt_en_ni (cnt_en_ni),
    .cnt_rst_ni(cnt_rst_ni),
    .op_o      (op)
  );

  burst_ctr_next #(.ADDR_W(ADDR_W)) u_next (
    .op_i  (op),
    .cur_i (addr_o),
    .load_i(addr_i),
    .nxt_o (nxt)
  );

  burst_ctr_reg #(.ADDR_W(ADDR_W)) u_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (nxt),
    .q_o   (addr_o)
  );

  a_r1_reset_zero: assert property (@(posedge clk_i)
    !rst_ni |-> addr_o == '0);

  a_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_rst_ni && !strobe_ni) |=> addr_o == $past(addr_i));

  a_r3_increment: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_rst_ni && strobe_ni && !cnt_en_ni) |=>
      addr_o == ADDR_W'($past(addr_o) + ADDR_W'(1)));

  a_r4_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_rst_ni |=> addr_o == '0);

  a_r5_strobe_over_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_rst_ni && !strobe_ni && !cnt_en_ni) |=> addr_o == $past(addr_i));

  a_r6_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_rst_ni && strobe_ni && !cnt_en_ni && addr_o == ADDR_MAX) |=> addr_o == '0);

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_rst_ni && strobe_ni && cnt_en_ni) |=> $stable(addr_o));
endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
  localparam int unsigned W = 15;
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] addr_in = '0;
  logic         stb_n = 1'b1, cen_n = 1'b1, crst_n = 1'b1;
  logic [W-1:0] addr_out;
  logic [W-1:0] exp_addr = '0;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  burst_addr_gen #(.ADDR_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr_in),
    .strobe_ni(stb_n), .cnt_en_ni(cen_n), .cnt_rst_ni(crst_n),
    .addr_o(addr_out)
  );

  function automatic logic [W-1:0] model(logic [W-1:0] cur, logic [W-1:0] ld,
                                         logic s_n, logic c_n, logic r_n);
    if (!r_n)      return '0;
    else if (!s_n) return ld;
    else if (!c_n) return W'(cur + W'(1));
    else           return cur;
  endfunction

  task automatic check(string tag);
    n_chk++;
    if (addr_out !== exp_addr) begin
      n_bad++;
      $display("FAIL %s: addr_o=%h expected=%h", tag, addr_out, exp_addr);
    end
  endtask

  // drive at negedge, clock it, sample 1ns after the edge
  task automatic step(logic s_n, logic c_n, logic r_n, logic [W-1:0] a, string tag);
    @(negedge clk);
    stb_n = s_n; cen_n = c_n; crst_n = r_n; addr_in = a;
    exp_addr = model(exp_addr, a, s_n, c_n, r_n);
    @(posedge clk);
    #1;
    check(tag);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: addr_o=%h expected=%h", addr_out, exp_addr);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(posedge clk);
    #1;
    exp_addr = '0;
    check("R1 reset value");
    @(negedge clk);
    rst_n = 1'b1;

    step(0, 1, 1, 15'h0010, "R2 load");
    step(1, 0, 1, 15'h7abc, "R3 inc 1");
    step(1, 0, 1, 15'h0000, "R3 inc 2");
    step(1, 1, 1, 15'h1234, "R7 hold ignores addr_i");
    step(1, 1, 1, 15'h4321, "R7 hold again");
    step(0, 1, 1, TOP - W'(1), "R2 load near top");
    step(1, 0, 1, 15'h0, "R3 inc to top");
    step(1, 0, 1, 15'h0, "R6 wrap to zero");
    step(1, 0, 1, 15'h0, "R3 inc after wrap");
    step(0, 0, 1, 15'h2222, "R5 strobe over count enable");
    step(0, 1, 0, 15'h3333, "R4 clear over strobe");
    step(0, 1, 1, 15'h0555, "R2 reload");
    step(1, 0, 0, 15'h0666, "R4 clear over count enable");
    step(0, 0, 0, TOP, "R4 clear over all");
    step(0, 1, 1, TOP, "R2 load top");
    step(0, 0, 1, TOP, "R5 load top with count enable");

    // asynchronous reset between edges
    @(negedge clk);
    stb_n = 1'b1; cen_n = 1'b1; crst_n = 1'b1;
    rst_n = 1'b0;
    #1;
    exp_addr = '0;
    check("R1 async clear");
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 4000; i++) begin
      int unsigned r = $urandom % 16;
      logic s_n = (r < 3) ? 1'b0 : 1'b1;
      logic c_n = (r < 11) ? 1'b0 : 1'b1;
      logic r_n = (r == 15 && ($urandom % 4 == 0)) ? 1'b0 : 1'b1;
      logic [W-1:0] a = ($urandom % 2) ? W'(TOP - W'($urandom % 8)) : W'($urandom);
      string tag;
      if (!r_n)      tag = "R4 random clear";
      else if (!s_n) tag = c_n ? "R2 random load" : "R5 random load";
      else if (!c_n) tag = (exp_addr == TOP) ? "R6 random wrap" : "R3 random inc";
      else           tag = "R7 random hold";
      step(s_n, c_n, r_n, a, tag);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule